// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller with CBR Refresh

This block sits between a simple synchronous host port and a 1M x 16 EDO page-mode DRAM. The host presents a word address, a write flag, 16 bits of write data and two byte enables. It waits for `req_ready`. Read data comes back with a one-cycle valid pulse. The controller splits the word address into a row and a column and places them in turn on a shared 10-bit address bus. It generates the row strobe, two byte-lane column strobes, write enable and output enable. It also controls when the write-data drivers are enabled.

After an access the row stays open. A later request to the same row is served as a page cycle that toggles only the column strobes. A request to a different row first precharges and then opens the new row. A free-running interval timer requests a CAS-before-RAS refresh about every 15.6 us. This spreads 1,024 refreshes over 16 ms. A pending refresh wins over new host requests as soon as the current access ends, and any open row is closed first. Every DRAM timing limit is a parameter counted in clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high (inactive). The data drivers are off, `rd_valid` is low and `req_ready` is high.
- R2: The row is the upper ROW_W bits of `req_addr` and must be on `dram_addr` when the row strobe falls. The column is the lower COL_W bits and must be on `dram_addr` when a column strobe falls.
- R3: `dram_ucas_n` falls only when `req_be[1]` is set and carries bits 15:8. `dram_lcas_n` falls only when `req_be[0]` is set and carries bits 7:0. A write changes only the enabled bytes. With `req_be` = 00, neither strobe falls.
- R4: For each accepted read, `rd_valid` is high for exactly one cycle. `rd_data` then holds the stored byte on every enabled lane and zero on every disabled lane.
- R5: A request whose row equals the open row, with no refresh since that row was opened, is served without any row-strobe transition.
- R6: Before the row strobe falls to open a row, it has been high for at least T_RP cycles.
- R7: A refresh drives both column strobes low for at least T_CSR cycles before the row strobe falls. Write enable stays high and no row address is latched. Refreshes recur every REF_INTERVAL cycles.
- R8: A pending refresh is started before any further host request is accepted. An open row is first closed for T_RP cycles, so the refresh interval is never stretched by more than one access.
- R9: Output enable is low only during read column cycles, and write enable is low only during write column cycles. The data drivers are on exactly while write enable is low.
- R10: `req_ready` is high only when the controller is idle and no refresh is pending. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after a request is taken.
- R11: A column strobe falls at least T_RCD cycles after the row strobe falls. It stays low for at least T_CAS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller can take a request |
| rd_data | output | 16 | Read data, disabled bytes zero |
| rd_valid | output | 1 | One-cycle read data strobe |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Write data toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the write-data drivers |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
A wrong open-row record shows up at the strobes on the very next access. Either the row strobe pulses for what should be a page hit, or a stale row is used and the bench memory model returns another word in the same read. A corrupted lane mask shows up as a wrong strobe at the column edge, and as a byte that differs in the following read of that word. A refresh pending flag that sticks, or is lost, shows up within one refresh interval. The bench measures refresh gaps outside the allowed window and refresh counts that are wrong over an idle stretch.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int DQ_W  = 16;
  localparam int LANES = DQ_W / 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_COL,
    S_CASPRE,
    S_REF_CLOSE,
    S_REF_CSR,
    S_REF_RAS,
    S_REF_PRE
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/edo_lane_ctl.sv
module edo_lane_ctl
  import edo_pkg::*;
(
  input  logic [LANES-1:0] be,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  rd_lane
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_lane[g*8 +: 8] = be[g] ? dq_in[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_CSR     = 1,
  parameter int T_RAS_REF = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  input  logic [LANES-1:0]       req_be,
  input  logic                   ref_pend,
  input  logic [DQ_W-1:0]        rd_lane,
  output logic                   ref_ack,
  output logic                   req_ready,
  output logic [LANES-1:0]       cur_be,
  output logic [DQ_W-1:0]        rd_data,
  output logic                   rd_valid,
  output logic [imax(ROW_W,COL_W)-1:0] dram_addr,
  output logic                   ras_n,
  output logic [LANES-1:0]       cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [DQ_W-1:0]        dq_out,
  output logic                   dq_oe
);
  localparam int AW   = ROW_W + COL_W;
  localparam int MW   = imax(ROW_W, COL_W);
  localparam int TMAX = imax(imax(imax(T_RP, T_RCD), imax(T_CAS, T_CP)), imax(T_CSR, T_RAS_REF));
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_e        st;
  logic [CW-1:0]     cnt;
  logic              row_open;
  logic [ROW_W-1:0]  open_row;
  logic              l_wr;
  logic [AW-1:0]     l_addr;
  logic [DQ_W-1:0]   l_wdata;
  logic [LANES-1:0]  l_be;

  logic [ROW_W-1:0]  req_row;
  logic              hit;
  logic              c_wr;
  logic [COL_W-1:0]  c_col;
  logic [DQ_W-1:0]   c_wdata;
  logic [LANES-1:0]  c_be;

  assign req_row   = req_addr[AW-1:COL_W];
  assign hit       = row_open && (req_row == open_row);
  assign req_ready = (st == S_IDLE) && !ref_pend;
  assign ref_ack   = (st == S_REF_CSR);
  assign cur_be    = l_be;

  // Column fields come straight from the host on a page hit, else from the latch.
  always_comb begin
    if (st == S_IDLE) begin
      c_wr    = req_write;
      c_col   = req_addr[COL_W-1:0];
      c_wdata = req_wdata;
      c_be    = req_be;
    end else begin
      c_wr    = l_wr;
      c_col   = l_addr[COL_W-1:0];
      c_wdata = l_wdata;
      c_be    = l_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      row_open <= 1'b0;
      open_row <= '0;
      l_wr     <= 1'b0;
      l_addr   <= '0;
      l_wdata  <= '0;
      l_be     <= '0;
      ras_n    <= 1'b1;
      cas_n    <= '1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      dram_addr <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      unique case (st)
        S_IDLE: begin
          if (ref_pend) begin
            if (row_open) begin
              ras_n    <= 1'b1;
              row_open <= 1'b0;
              st       <= S_REF_CLOSE;
              cnt      <= CW'(T_RP - 1);
            end else begin
              cas_n <= '0;
              st    <= S_REF_CSR;
              cnt   <= CW'(T_CSR - 1);
            end
          end else if (req_valid) begin
            l_wr    <= req_write;
            l_addr  <= req_addr;
            l_wdata <= req_wdata;
            l_be    <= req_be;
            if (hit) begin
              dram_addr <= MW'(c_col);
              cas_n     <= ~c_be;
              we_n      <= ~c_wr;
              oe_n      <= c_wr;
              dq_oe     <= c_wr;
              dq_out    <= c_wdata;
              st        <= S_COL;
              cnt       <= CW'(T_CAS - 1);
            end else begin
              ras_n     <= 1'b1;
              row_open  <= 1'b0;
              dram_addr <= MW'(req_row);
              st        <= S_PRE;
              cnt       <= row_open ? CW'(T_RP - 1) : '0;
            end
          end
        end
        S_PRE: if (cnt == '0) begin
          ras_n    <= 1'b0;
          row_open <= 1'b1;
          open_row <= l_addr[AW-1:COL_W];
          st       <= S_ACT;
          cnt      <= CW'(T_RCD - 1);
        end
        S_ACT: if (cnt == '0) begin
          dram_addr <= MW'(c_col);
          cas_n     <= ~c_be;
          we_n      <= ~c_wr;
          oe_n      <= c_wr;
          dq_oe     <= c_wr;
          dq_out    <= c_wdata;
          st        <= S_COL;
          cnt       <= CW'(T_CAS - 1);
        end
        S_COL: if (cnt == '0) begin
          if (!l_wr) begin
            rd_data  <= rd_lane;
            rd_valid <= 1'b1;
          end
          cas_n <= '1;
          we_n  <= 1'b1;
          oe_n  <= 1'b1;
          dq_oe <= 1'b0;
          st    <= S_CASPRE;
          cnt   <= CW'(T_CP - 1);
        end
        S_CASPRE: if (cnt == '0) st <= S_IDLE;
        S_REF_CLOSE: if (cnt == '0) begin
          cas_n <= '0;
          st    <= S_REF_CSR;
          cnt   <= CW'(T_CSR - 1);
        end
        S_REF_CSR: if (cnt == '0) begin
          ras_n <= 1'b0;
          st    <= S_REF_RAS;
          cnt   <= CW'(T_RAS_REF - 1);
        end
        S_REF_RAS: if (cnt == '0) begin
          ras_n <= 1'b1;
          cas_n <= '1;
          st    <= S_REF_PRE;
          cnt   <= CW'(T_RP - 1);
        end
        S_REF_PRE: if (cnt == '0) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_CSR        = 1,
  parameter int T_RAS_REF    = 5,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ROW_W+COL_W-1:0]       req_addr,
  input  logic [15:0]                  req_wdata,
  input  logic [1:0]                   req_be,
  output logic                         req_ready,
  output logic [15:0]                  rd_data,
  output logic                         rd_valid,
  output logic [imax(ROW_W,COL_W)-1:0] dram_addr,
  output logic                         dram_ras_n,
  output logic                         dram_ucas_n,
  output logic                         dram_lcas_n,
  output logic                         dram_we_n,
  output logic                         dram_oe_n,
  output logic [15:0]                  dram_dq_out,
  output logic                         dram_dq_oe,
  input  logic [15:0]                  dram_dq_in
);
  logic             ref_pend;
  logic             ref_ack;
  logic [LANES-1:0] cur_be;
  logic [DQ_W-1:0]  rd_lane;
  logic [LANES-1:0] cas_n;

  assign dram_ucas_n = cas_n[1];
  assign dram_lcas_n = cas_n[0];

  edo_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (ref_ack),
    .pend(ref_pend)
  );

  edo_lane_ctl u_lane (
    .be     (cur_be),
    .dq_in  (dram_dq_in),
    .rd_lane(rd_lane)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS_REF(T_RAS_REF)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .ref_pend (ref_pend),
    .rd_lane  (rd_lane),
    .ref_ack  (ref_ack),
    .req_ready(req_ready),
    .cur_be   (cur_be),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .dram_addr(dram_addr),
    .ras_n    (dram_ras_n),
    .cas_n    (cas_n),
    .we_n     (dram_we_n),
    .oe_n     (dram_oe_n),
    .dq_out   (dram_dq_out),
    .dq_oe    (dram_dq_oe)
  );
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_ucas_n,
  input logic dram_lcas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !dram_oe_n |-> (dram_we_n && !dram_dq_oe)); // R9

  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> dram_dq_oe); // R9

  AST_RD_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R4

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n)); // R10

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_ucas_n && !dram_lcas_n)
      |-> ($past(!dram_ucas_n && !dram_lcas_n) && dram_we_n)); // R7
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .dram_ras_n (dram_ras_n),
  .dram_ucas_n(dram_ucas_n),
  .dram_lcas_n(dram_lcas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/sim_edo_dram_ctrl.sv
module sim_edo_dram_ctrl;
  localparam int RW = 3, CW = 3, AW = 6, MW = 3, NW = 64;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, T_CP = 1, T_CSR = 1, T_RAS_REF = 4;
  localparam int RI = 150;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, req_valid, req_write, req_ready, rd_valid;
  logic [AW-1:0] req_addr;
  logic [15:0] req_wdata, rd_data, dram_dq_out, dram_dq_in;
  logic [1:0] req_be;
  logic [MW-1:0] dram_addr;
  logic dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  edo_dram_ctrl #(
    .ROW_W(RW), .COL_W(CW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS_REF(T_RAS_REF), .REF_INTERVAL(RI)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
    .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  // DRAM model and pin-timing monitor
  logic [15:0]   mem [0:NW-1];
  logic [RW-1:0] row_l = '0;
  logic [CW-1:0] col_l = '0;
  logic [1:0]    last_strobe = 2'b00;
  logic p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1;
  int ras_falls = 0, cbr_cnt = 0, host_ev = 0;
  int ras_hi = 100, ras_lo = 0, cas_lo = 0;
  int cyc = 0, last_cbr = 0, min_gap = 1000000, max_gap = 0;
  int mon_checks = 0, mon_fails = 0;

  assign dram_dq_in = (!dram_oe_n && !dram_ras_n) ? mem[{row_l, col_l}] : 16'h0000;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      mon_checks++;
      if (!dram_oe_n && (!dram_we_n || dram_dq_oe)) begin
        mon_fails++;
        $display("FAIL R9 oe_n low: got we_n=%b dq_oe=%b expected we_n=1 dq_oe=0", dram_we_n, dram_dq_oe);
      end
      if (!dram_we_n && !dram_dq_oe) begin
        mon_fails++;
        $display("FAIL R9 we_n low: got dq_oe=%b expected 1", dram_dq_oe);
      end
      if (p_ras && !dram_ras_n) begin
        mon_checks++;
        if (ras_hi < T_RP) begin
          mon_fails++;
          $display("FAIL R6/R8 row strobe high %0d cycles, expected >= %0d", ras_hi, T_RP);
        end
        if (!dram_ucas_n && !dram_lcas_n) begin
          cbr_cnt++;
          if (cbr_cnt > 1) begin
            if (cyc - last_cbr < min_gap) min_gap = cyc - last_cbr;
            if (cyc - last_cbr > max_gap) max_gap = cyc - last_cbr;
          end
          last_cbr = cyc;
          if (cas_lo < T_CSR || !dram_we_n) begin
            mon_fails++;
            $display("FAIL R7 CBR setup %0d we_n=%b, expected >= %0d we_n=1", cas_lo, dram_we_n, T_CSR);
          end
        end else begin
          ras_falls++;
          row_l = dram_addr[RW-1:0];
        end
      end
      if (!dram_ras_n && ((p_u && !dram_ucas_n) || (p_l && !dram_lcas_n))) begin
        host_ev++;
        last_strobe = {!dram_ucas_n, !dram_lcas_n};
        col_l = dram_addr[CW-1:0];
        mon_checks++;
        if (ras_lo < T_RCD) begin
          mon_fails++;
          $display("FAIL R11 row-to-column %0d cycles, expected >= %0d", ras_lo, T_RCD);
        end
        if (!dram_we_n) begin
          if (!dram_ucas_n) mem[{row_l, col_l}][15:8] = dram_dq_out[15:8];
          if (!dram_lcas_n) mem[{row_l, col_l}][7:0]  = dram_dq_out[7:0];
        end
      end
      if ((!p_u || !p_l) && dram_ucas_n && dram_lcas_n) begin
        mon_checks++;
        if (cas_lo < T_CAS) begin
          mon_fails++;
          $display("FAIL R11 column strobe low %0d cycles, expected >= %0d", cas_lo, T_CAS);
        end
      end
      if (dram_ras_n) begin ras_hi++; ras_lo = 0; end
      else begin ras_lo++; ras_hi = 0; end
      if (!dram_ucas_n || !dram_lcas_n) cas_lo++; else cas_lo = 0;
      p_ras = dram_ras_n; p_u = dram_ucas_n; p_l = dram_lcas_n;
    end
  end

  int vectors = 0, fails = 0;
  bit wd_fail = 1'b0;
  logic [15:0] shadow [0:NW-1];
  bit exp_open = 1'b0;
  int exp_row = 0, ref_mark = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==",
             vectors + mon_checks + (wd_fail ? 1 : 0), fails + mon_fails + (wd_fail ? 1 : 0));
    $finish;
  endtask

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", what, got, exp);
    end
  endtask

  task automatic access(input bit wr, input int a, input logic [15:0] d, input logic [1:0] be);
    int row, col, rf0, ev0, refnow;
    bit hit;
    logic [15:0] m;
    row = a >> CW;
    col = a & ((1 << CW) - 1);
    while (!req_ready) @(negedge clk);
    rf0 = ras_falls; ev0 = host_ev;
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready after accept", int'(req_ready), 0);
    refnow = cbr_cnt;
    if (refnow != ref_mark) exp_open = 1'b0;
    hit = exp_open && (exp_row == row);
    if (wr) begin
      while (!req_ready) @(negedge clk);
    end else begin
      while (!rd_valid) @(negedge clk);
      m = {{8{be[1]}}, {8{be[0]}}};
      chk(rd_data == (shadow[a] & m), "R4 read data", int'(rd_data), int'(shadow[a] & m));
    end
    if (hit) chk(ras_falls == rf0, "R5 page hit row strobe falls", ras_falls - rf0, 0);
    else begin
      chk(ras_falls == rf0 + 1, "R6 row open count", ras_falls - rf0, 1);
      chk(int'(row_l) == row, "R2 row address", int'(row_l), row);
    end
    if (be != 2'b00) begin
      chk(host_ev == ev0 + 1, "R3 strobe events", host_ev - ev0, 1);
      chk(last_strobe == be, "R3 strobe lanes", int'(last_strobe), int'(be));
      chk(int'(col_l) == col, "R2 column address", int'(col_l), col);
    end else chk(host_ev == ev0, "R3 no strobe with zero enables", host_ev - ev0, 0);
    if (wr) begin
      if (be[1]) shadow[a][15:8] = d[15:8];
      if (be[0]) shadow[a][7:0]  = d[7:0];
    end
    exp_open = 1'b1; exp_row = row; ref_mark = refnow;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int c0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'b11111,
        "R1 strobes after reset", int'({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}), 31);
    chk(!dram_dq_oe && !rd_valid && req_ready, "R1 drivers/valid/ready",
        int'({dram_dq_oe, rd_valid, req_ready}), 1);

    for (int a = 0; a < NW; a++) access(1'b1, a, 16'(a * 257) ^ 16'h5A3C, 2'b11);
    for (int a = 0; a < NW; a++) access(1'b1, a, 16'(a * 4099 + 7), 2'(a % 4));
    for (int k = 0; k < NW; k++) access(1'b0, (k * 9) % NW, 16'h0, 2'((k % 3) + 1));
    for (int a = 0; a < NW; a++) access(1'b0, a, 16'h0, 2'b11);

    // R7 refresh continues while idle
    c0 = cbr_cnt;
    repeat (3 * RI) @(negedge clk);
    chk((cbr_cnt - c0 >= 2) && (cbr_cnt - c0 <= 3), "R7 refreshes in idle window", cbr_cnt - c0, 3);
    chk(min_gap >= RI - 20, "R7 minimum refresh gap", min_gap, RI);
    chk(max_gap <= RI + 20, "R8 maximum refresh gap", max_gap, RI);
    chk(cbr_cnt >= 2, "R7 refresh seen", cbr_cnt, 2);
    report();
  end
endmodule